// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

The block gathers a vector of up to 64 words from memory positions `base_addr + i*stride` (word addresses, wrapping modulo 2^16) and delivers them, in element order, on a one-word-per-cycle output stream. The memory behind it is modelled inside the block as eight word-interleaved banks. Each bank takes one access at a time, stays occupied for six clocks after accepting one, and answers twelve clocks after the request. The engine sends at most one request per clock. When the next request targets a bank that is still occupied, the engine waits.

A load begins when `start` is pulsed with a non-zero `length`. The load finishes when the last element has been delivered. `done` then rises and `cycle_count` reports how many cycles the load took. The controller has four states. `ST_IDLE` is the state after reset. `ST_ISSUE` sends requests, and `ST_DRAIN` waits for the returns that are still outstanding. `ST_DONE` holds the result. An accepted start moves `ST_IDLE` or `ST_DONE` to `ST_ISSUE`. Sending the request for the final element moves `ST_ISSUE` to `ST_DRAIN`. Delivering the final element moves `ST_DRAIN` to `ST_DONE`. No other transitions exist.

Top module: `strided_vector_load`

## Requirements
- R1: After reset, `done` and `elem_valid` are low and `cycle_count` is 0.
- R2: Element i reads word address a = (base_addr + i*stride) mod 2^16. The bank is a[2:0] and the row is a[15:3]. The returned data is 32'h5A00_0000 OR a, with a zero-extended to 32 bits.
- R3: At most one request is sent per cycle, in element order. With stride 1 no request ever waits, so a 64-element load takes 76 cycles.
- R4: A bank accepts a new access no sooner than 6 cycles after its previous one. With a stride that is a multiple of 8, every request after the first waits for the full 6 cycles, so a 64-element load takes 391 cycles.
- R5: A request that must wait also holds back every later request. Elements appear with `elem_idx` counting 0, 1, 2 and so on, each exactly once.
- R6: Each element appears on the output exactly 12 cycles after the cycle in which its request was sent.
- R7: `done` rises in the cycle after the last element is delivered and stays high until a new load is accepted. While `done` is high, `cycle_count` holds the number of cycles from the first request cycle through the last delivery cycle. That value equals the last request's offset plus 13.
- R8: A `start` with `length` equal to 0 is ignored. `done` and `cycle_count` stay as they were, and no element is produced.
- R9: A `start` that arrives while a load is in progress is ignored. The running load's elements and its timing are unchanged.
- R10: `length` may be 1 to 64. A start accepted from `ST_DONE` clears `done` and resets `cycle_count` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a load (taken only in ST_IDLE or ST_DONE with non-zero length) |
| base_addr | input | 16 | Word address of element 0 |
| stride | input | 16 | Word distance between consecutive elements |
| length | input | 7 | Number of elements, 1 to 64 |
| elem_valid | output | 1 | An element is on the output this cycle |
| elem_idx | output | 6 | Index of the element on the output |
| elem_data | output | 32 | Data of the element on the output |
| done | output | 1 | Load complete, held until the next accepted start |
| cycle_count | output | 16 | Cycles taken by the load |

## Verification
Two things can happen in the same cycle. A request can leave for one bank while an element from an earlier request returns from another bank. A request can also be held back by a busy bank while that same bank still has data in its return pipe. Loads longer than twelve elements produce the overlap, and strides 2, 4, 8 and 32 make the banks recur faster than their busy time. The bench predicts every request cycle with its own bank-occupancy model and judges each returned element on three points: its index, its data and the cycle in which it arrives. It also judges the total cycle count against the same model.

// File: rtl/slv_pkg.sv
package slv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE
    } slv_state_e;

endpackage

// File: rtl/slv_addr_gen.sv
module slv_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  idx
);

    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            idx      <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr     <= base;
            idx      <= '0;
            stride_q <= stride;
        end else if (step) begin
            addr <= addr + stride_q;
            idx  <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/slv_bank.sv
module slv_bank #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 32,
    parameter int                IDX_W       = 6,
    parameter int                BANK_W      = 3,
    parameter int                BANK_ID     = 0,
    parameter int                BUSY_CYCLES = 6,
    parameter int                LATENCY     = 12,
    parameter logic [DATA_W-1:0] DATA_TAG    = '0,
    localparam int               ROW_W       = ADDR_W - BANK_W,
    localparam int               BC_W        = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ROW_W-1:0]  row,
    input  logic [IDX_W-1:0]  idx,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_ID);
    localparam logic [BC_W-1:0]   RELOAD   = BC_W'(BUSY_CYCLES - 1);

    logic [BC_W-1:0]    busy_q;
    logic [ADDR_W-1:0]  word;
    logic [DATA_W-1:0]  entry_data;
    logic [LATENCY-1:0] vld_q;
    logic [DATA_W-1:0]  dat_q [LATENCY];
    logic [IDX_W-1:0]   idx_q [LATENCY];

    assign ready      = (busy_q == '0);
    assign word       = {row, BANK_SEL};
    assign entry_data = DATA_TAG | DATA_W'(word);

    // occupancy counter: reloads on each accepted access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_q <= '0;
        else if (req)
            busy_q <= RELOAD;
        else if (busy_q != '0)
            busy_q <= busy_q - 1'b1;
    end

    // fixed-latency return pipe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < LATENCY; i++) begin
                dat_q[i] <= '0;
                idx_q[i] <= '0;
            end
        end else begin
            vld_q    <= {vld_q[LATENCY-2:0], req};
            dat_q[0] <= entry_data;
            idx_q[0] <= idx;
            for (int i = 1; i < LATENCY; i++) begin
                dat_q[i] <= dat_q[i-1];
                idx_q[i] <= idx_q[i-1];
            end
        end
    end

    assign rd_valid = vld_q[LATENCY-1];
    assign rd_data  = dat_q[LATENCY-1];
    assign rd_idx   = idx_q[LATENCY-1];

endmodule

// File: rtl/strided_vector_load.sv
module strided_vector_load
    import slv_pkg::*;
#(
    parameter int                NUM_BANKS   = 8,
    parameter int                BUSY_CYCLES = 6,
    parameter int                LATENCY     = 12,
    parameter int                MAX_LEN     = 64,
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 32,
    parameter int                CNT_W       = 16,
    parameter logic [DATA_W-1:0] DATA_TAG    = 32'h5A00_0000,
    localparam int               LEN_W       = $clog2(MAX_LEN + 1),
    localparam int               IDX_W       = $clog2(MAX_LEN),
    localparam int               BANK_W      = $clog2(NUM_BANKS),
    localparam int               ROW_W       = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  length,
    output logic              elem_valid,
    output logic [IDX_W-1:0]  elem_idx,
    output logic [DATA_W-1:0] elem_data,
    output logic              done,
    output logic [CNT_W-1:0]  cycle_count
);

    slv_state_e state_q, state_d;

    logic              accept, in_issue, in_run;
    logic              issue_fire, last_issue, last_deliver;
    logic [LEN_W-1:0]  len_q, deliv_q;
    logic [CNT_W-1:0]  cyc_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_idx;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;

    logic [NUM_BANKS-1:0] bank_ready, bank_req, rd_valid;
    logic [DATA_W-1:0]    rd_data [NUM_BANKS];
    logic [IDX_W-1:0]     rd_idx  [NUM_BANKS];

    assign cur_bank = cur_addr[BANK_W-1:0];
    assign cur_row  = cur_addr[ADDR_W-1:BANK_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // state decode
    always_comb begin
        done     = (state_q == ST_DONE);
        in_issue = (state_q == ST_ISSUE);
        in_run   = in_issue || (state_q == ST_DRAIN);
        accept   = start && (length != '0) &&
                   ((state_q == ST_IDLE) || (state_q == ST_DONE));
    end

    assign issue_fire   = in_issue && bank_ready[cur_bank];
    assign last_issue   = issue_fire && (cur_idx == len_q - 1'b1);
    assign last_deliver = elem_valid && (deliv_q == len_q - 1'b1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)       state_d = ST_ISSUE;
            ST_ISSUE: if (last_issue)   state_d = ST_DRAIN;
            ST_DRAIN: if (last_deliver) state_d = ST_DONE;
            ST_DONE:  if (accept)       state_d = ST_ISSUE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // length, delivery and cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            deliv_q <= '0;
            cyc_q   <= '0;
        end else if (accept) begin
            len_q   <= length;
            deliv_q <= '0;
            cyc_q   <= '0;
        end else begin
            if (elem_valid) deliv_q <= deliv_q + 1'b1;
            if (in_run)     cyc_q   <= cyc_q + 1'b1;
        end
    end

    assign cycle_count = cyc_q;

    slv_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (issue_fire),
        .base   (base_addr),
        .stride (stride),
        .addr   (cur_addr),
        .idx    (cur_idx)
    );

    always_comb begin
        for (int k = 0; k < NUM_BANKS; k++)
            bank_req[k] = issue_fire && (cur_bank == BANK_W'(k));
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        slv_bank #(
            .ADDR_W      (ADDR_W),
            .DATA_W      (DATA_W),
            .IDX_W       (IDX_W),
            .BANK_W      (BANK_W),
            .BANK_ID     (k),
            .BUSY_CYCLES (BUSY_CYCLES),
            .LATENCY     (LATENCY),
            .DATA_TAG    (DATA_TAG)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (bank_req[k]),
            .row      (cur_row),
            .idx      (cur_idx[IDX_W-1:0]),
            .ready    (bank_ready[k]),
            .rd_valid (rd_valid[k]),
            .rd_data  (rd_data[k]),
            .rd_idx   (rd_idx[k])
        );
    end

    // merge returns: requests are one per cycle, so at most one bank answers
    always_comb begin
        elem_valid = |rd_valid;
        elem_data  = '0;
        elem_idx   = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (rd_valid[k]) begin
                elem_data = elem_data | rd_data[k];
                elem_idx  = elem_idx  | rd_idx[k];
            end
        end
    end

endmodule

// File: rtl/slv_checker.sv
module slv_checker #(
    parameter int NUM_BANKS   = 8,
    parameter int BUSY_CYCLES = 6,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_req,
    input logic                 elem_valid,
    input logic [IDX_W-1:0]     elem_idx,
    input logic                 done,
    input logic [CNT_W-1:0]     cycle_count
);

    localparam int GAP_W = $clog2(BUSY_CYCLES + 1);

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_gap
        logic [GAP_W-1:0] gap;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gap <= GAP_W'(BUSY_CYCLES);
            else if (bank_req[k])
                gap <= GAP_W'(1);
            else if (gap < GAP_W'(BUSY_CYCLES))
                gap <= gap + 1'b1;
        end
        // R4
        bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_req[k] |-> (gap >= GAP_W'(BUSY_CYCLES)));
    end

    logic [IDX_W-1:0] want_idx;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            want_idx <= '0;
        else if (done)
            want_idx <= '0;
        else if (elem_valid)
            want_idx <= want_idx + 1'b1;
    end

    // R5
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> (elem_idx == want_idx));

    // R7
    done_after_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(elem_valid));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !elem_valid);

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(cycle_count));

endmodule

bind strided_vector_load slv_checker #(
    .NUM_BANKS   (NUM_BANKS),
    .BUSY_CYCLES (BUSY_CYCLES),
    .IDX_W       (IDX_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_req    (bank_req),
    .elem_valid  (elem_valid),
    .elem_idx    (elem_idx),
    .done        (done),
    .cycle_count (cycle_count)
);

// File: tb/strided_vector_load_test.sv
module strided_vector_load_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_i = '0;
    logic [15:0] stride_i = '0;
    logic [6:0]  length_i = '0;
    logic        elem_valid;
    logic [5:0]  elem_idx;
    logic [31:0] elem_data;
    logic        done;
    logic [15:0] cycle_count;

    strided_vector_load uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .base_addr   (base_i),
        .stride      (stride_i),
        .length      (length_i),
        .elem_valid  (elem_valid),
        .elem_idx    (elem_idx),
        .elem_data   (elem_data),
        .done        (done),
        .cycle_count (cycle_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int base_cyc = 0;

    typedef struct {
        int          idx;
        logic [31:0] data;
        int          due;
    } item_t;

    item_t exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop the scoreboard as elements emerge
    always @(negedge clk) begin
        if (rst_n && elem_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected element", elem_idx, -1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(elem_idx == it.idx[5:0], "R5", "element index", elem_idx, it.idx);
                check(elem_data == it.data, "R2", "element data", elem_data, it.data);
                check(cyc == base_cyc + it.due, "R6", "arrival offset",
                      cyc - base_cyc, it.due);
            end
        end
    end

    // driver: predicts issue cycles from bank occupancy, then runs the load
    task automatic run_load(input logic [15:0] b, input logic [15:0] s, input int n,
                            input string req, input bit poke);
        int          free_t[8];
        int          t;
        int          total;
        int          bk;
        logic [15:0] a;
        foreach (free_t[k]) free_t[k] = 0;
        t = -1;
        for (int i = 0; i < n; i++) begin
            a  = b + 16'(i) * s;
            bk = int'(a[2:0]);
            t  = (t + 1 > free_t[bk]) ? t + 1 : free_t[bk];
            free_t[bk] = t + 6;
            exp_q.push_back('{i, 32'h5A00_0000 | {16'h0000, a}, t + 12});
        end
        total = t + 13;
        @(negedge clk);
        base_i = b; stride_i = s; length_i = 7'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_cyc = cyc;
        check(!done && cycle_count == 16'd0, "R10", "restart clears count", cycle_count, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            base_i = 16'h1234; stride_i = 16'd8; length_i = 7'd3; start = 1'b1; // R9
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc - base_cyc < 2000) @(negedge clk);
        check(done == 1'b1, req, "done reached", done, 1);
        check(cyc - base_cyc == total, "R7", "done offset", cyc - base_cyc, total);
        check(cycle_count == 16'(total), req, "cycle_count total", cycle_count, total);
        check(exp_q.size() == 0, "R5", "undelivered elements", exp_q.size(), 0);
        repeat (2) @(negedge clk);
        check(done && cycle_count == 16'(total), "R7", "done and count held", cycle_count, total);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !elem_valid && cycle_count == 16'd0, "R1", "reset state",
              {done, elem_valid}, 0);
        rst_n = 1'b1;

        run_load(16'd0,    16'd1,  64, "R3", 1'b0);   // 76 cycles, no stall
        run_load(16'd0,    16'd32, 64, "R4", 1'b0);   // 391 cycles, full serialization
        run_load(16'd5,    16'd2,  20, "R4", 1'b0);   // four banks recur too fast
        run_load(16'd3,    16'd3,  17, "R3", 1'b0);   // odd stride, never stalls
        run_load(16'hFFFC, 16'd8,  5,  "R2", 1'b0);   // address wraps, single bank
        run_load(16'd7,    16'd0,  1,  "R10", 1'b0);  // shortest load

        begin : zero_len  // R8
            logic [15:0] held;
            held = cycle_count;
            @(negedge clk);
            length_i = 7'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 3; i++) begin
                check(done && !elem_valid && cycle_count == held, "R8",
                      "zero-length start ignored", cycle_count, held);
                @(negedge clk);
            end
        end

        run_load(16'd0,   16'd4, 10, "R9", 1'b1);     // start during a load ignored
        run_load(16'd100, 16'd5, 64, "R3", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule